// File: doc/BRIEF.md
# Functional Reset Phase Sequencer

This block steps a chip through a functional reset made of three ordered phases, each held for a fixed number of clock cycles set by parameters. Five event sources can request a reset: an external reset pin, a fatal error from the code or data flash, a 4.5 V low-voltage detector, a clock monitor that sees a frequency above or below its reference, and a crystal oscillator monitor that sees a frequency below its reference. A request from any of them starts a sequence. A request that arrives while a sequence is running starts it again.

A 16-bit configuration register holds one short-sequence bit per source. With the bit clear, the source's sequence runs the first, second and third phases in that order. With the bit set, the sequence skips the first two phases and starts at the third. Software reads and writes the register through a simple port that carries a privilege code. Only supervisor and test privilege can change it.

While a phase is active, the block drives a functional reset output and reports the current phase. When the third phase ends, it returns to idle and pulses a done flag for one cycle. It also keeps a one-hot record of the source that started the most recent sequence.

Top module: `reset_phase_sequencer`

## Requirements
- R1: After power-on reset, the configuration reads 0x0000, phaseCode is 0 (idle), and funcRst, rstDone and srcLatched are all 0.
- R2: With a source's short bit clear, its request produces phaseCode 1 for P1_CYC (8) cycles, then 2 for P2_CYC (16) cycles, then 3 for P3_CYC (4) cycles, in that order. The sequence starts in the cycle after the edge that samples the request.
- R3: With a source's short bit set, its request produces phaseCode 3 for P3_CYC cycles, and phaseCode never shows 1 or 2 during that sequence.
- R4: Register bit 0 belongs to the external reset, bit 1 to the flash fatal error, bit 2 to the low-voltage detect, bit 3 to the clock-frequency monitor and bit 4 to the oscillator-low monitor (the same index as the evtReq bit). Bits 15 to 5 read as 0 and ignore writes.
- R5: A write takes effect when privMode is 2'b01 (supervisor) or 2'b10 (test). With privMode 2'b00 (user) or 2'b11, a write is ignored. regRdData shows the register in every mode.
- R6: When several requests arrive in the same cycle, the lowest evtReq index wins, so the external reset has the highest priority. The winner's short bit picks the start phase.
- R7: The short bit is sampled when the sequence starts. A register write during a running sequence does not change that sequence, but it does apply to the next one.
- R8: A request during an active sequence restarts it at the start phase selected for the new winning source, with that phase's full duration.
- R9: funcRst is 1 exactly while phaseCode is nonzero. rstDone is 1 for exactly the one cycle after the third phase completes.
- R10: srcLatched holds the one-hot evtReq bit of the source that started the latest sequence, and keeps it until the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| evtReq | input | 5 | Reset requests; bit 0 external, 1 flash, 2 low-voltage, 3 clock monitor, 4 oscillator monitor |
| regWrEn | input | 1 | Write strobe for the configuration register |
| regWrData | input | 16 | Write data |
| privMode | input | 2 | Privilege code: 00 user, 01 supervisor, 10 test, 11 treated as user |
| regRdData | output | 16 | Configuration register contents |
| phaseCode | output | 2 | 0 idle, 1 first phase, 2 second phase, 3 third phase |
| funcRst | output | 1 | Functional reset, high while any phase is active |
| rstDone | output | 1 | One-cycle pulse after the third phase completes |
| srcLatched | output | 5 | One-hot source of the latest sequence |

## Verification
A request sampled at an edge shows up on phaseCode, funcRst and srcLatched right after that edge. Each phase then holds for its full parameter count. rstDone rises one cycle after the last cycle of the third phase, and a register write shows on regRdData one edge after it is driven. The bench drives every input on the falling edge and samples the outputs on the next falling edge, so each result is read half a cycle after the rising edge that produces it. Phase lengths are checked by counting, edge by edge, how many samples show each phaseCode value.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ONE   = 2'd1,
    PH_TWO   = 2'd2,
    PH_THREE = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadCnt;   // reload the phase duration counter
    phase_e loadPh;    // phase whose duration is loaded
    logic   latchSrc;  // capture the winning source
  } seqStrobe_t;

  localparam logic [1:0] MODE_USER  = 2'b00;
  localparam logic [1:0] MODE_SUPER = 2'b01;
  localparam logic [1:0] MODE_TEST  = 2'b10;

endpackage

// File: rtl/rps_dpath.sv
module rps_dpath
  import rps_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int REG_W   = 16,
  parameter int P1_CYC  = 8,
  parameter int P2_CYC  = 16,
  parameter int P3_CYC  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtReq,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [1:0]         privMode,
  input  seqStrobe_t         strobe,
  output logic [REG_W-1:0]   regRdData,
  output logic               anyReq,
  output logic               winShort,
  output logic               cntZero,
  output logic [NUM_SRC-1:0] srcLatched
);

  localparam int MAX12 = (P1_CYC > P2_CYC) ? P1_CYC : P2_CYC;
  localparam int MAXC  = (MAX12 > P3_CYC) ? MAX12 : P3_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DUR1 = CNT_W'(P1_CYC - 1);
  localparam logic [CNT_W-1:0] DUR2 = CNT_W'(P2_CYC - 1);
  localparam logic [CNT_W-1:0] DUR3 = CNT_W'(P3_CYC - 1);

  logic [NUM_SRC-1:0] shortCfg;
  logic [NUM_SRC-1:0] winOneHot;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   durLoad;
  logic               wrAllowed;

  // register access control
  assign wrAllowed = regWrEn && ((privMode == MODE_SUPER) || (privMode == MODE_TEST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shortCfg <= '0;
    else if (wrAllowed) shortCfg <= regWrData[NUM_SRC-1:0];
  end

  generate
    if (REG_W > NUM_SRC) begin : g_pad
      assign regRdData = {{(REG_W - NUM_SRC){1'b0}}, shortCfg};
    end else begin : g_nopad
      assign regRdData = shortCfg;
    end
  endgenerate

  // lowest index wins: isolate lowest set bit
  assign anyReq    = |evtReq;
  assign winOneHot = evtReq & (~evtReq + NUM_SRC'(1));
  assign winShort  = |(winOneHot & shortCfg);

  // phase duration counter
  always_comb begin
    unique case (strobe.loadPh)
      PH_ONE:   durLoad = DUR1;
      PH_TWO:   durLoad = DUR2;
      PH_THREE: durLoad = DUR3;
      default:  durLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.loadCnt) cnt <= durLoad;
    else if (cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcLatched <= '0;
    else if (strobe.latchSrc) srcLatched <= winOneHot;
  end

  // R5: writes without privilege leave the register unchanged
  p_user_write_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (privMode != MODE_SUPER) && (privMode != MODE_TEST)) |=> $stable(regRdData));

  // R4: unused bits never take written ones
  p_upper_bits_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrAllowed && (|regWrData[REG_W-1:NUM_SRC])) |=> (regRdData[REG_W-1:NUM_SRC] == '0));

  // R10: latched source is one-hot or empty
  p_src_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcLatched));

  // R10: source record only changes on a request
  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> $stable(srcLatched));

endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl
  import rps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       winShort,
  input  logic       cntZero,
  output phase_e     phase,
  output seqStrobe_t strobe,
  output logic       funcRst,
  output logic       rstDone
);

  phase_e nextPh;
  logic   doneNext;

  always_comb begin
    nextPh          = phase;
    strobe.loadCnt  = 1'b0;
    strobe.loadPh   = PH_IDLE;
    strobe.latchSrc = 1'b0;
    doneNext        = 1'b0;
    if (anyReq) begin
      // start or restart at the winner's selected entry phase
      nextPh          = winShort ? PH_THREE : PH_ONE;
      strobe.loadCnt  = 1'b1;
      strobe.loadPh   = nextPh;
      strobe.latchSrc = 1'b1;
    end else if (cntZero) begin
      unique case (phase)
        PH_ONE: begin
          nextPh         = PH_TWO;
          strobe.loadCnt = 1'b1;
          strobe.loadPh  = PH_TWO;
        end
        PH_TWO: begin
          nextPh         = PH_THREE;
          strobe.loadCnt = 1'b1;
          strobe.loadPh  = PH_THREE;
        end
        PH_THREE: begin
          nextPh   = PH_IDLE;
          doneNext = 1'b1;
        end
        default: nextPh = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rstDone <= 1'b0;
    end else begin
      phase   <= nextPh;
      rstDone <= doneNext;
    end
  end

  assign funcRst = (phase != PH_IDLE);

  // R9: done only right after the third phase
  p_done_after_p3_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstDone |-> ($past(phase) == PH_THREE));

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rstDone |=> !rstDone);

  // R2: second phase is entered only from the first
  p_p2_from_p1_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_TWO) && ($past(phase) != PH_TWO)) |-> ($past(phase) == PH_ONE));

  // R8: leaving idle needs a request
  p_start_needs_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (($past(phase) == PH_IDLE) && (phase != PH_IDLE)) |-> $past(anyReq));

endmodule

// File: rtl/reset_phase_sequencer.sv
module reset_phase_sequencer
  import rps_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int REG_W   = 16,
  parameter int P1_CYC  = 8,
  parameter int P2_CYC  = 16,
  parameter int P3_CYC  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtReq,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [1:0]         privMode,
  output logic [REG_W-1:0]   regRdData,
  output logic [1:0]         phaseCode,
  output logic               funcRst,
  output logic               rstDone,
  output logic [NUM_SRC-1:0] srcLatched
);

  seqStrobe_t strobe;
  phase_e     phase;
  logic       anyReq;
  logic       winShort;
  logic       cntZero;

  rps_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .winShort (winShort),
    .cntZero  (cntZero),
    .phase    (phase),
    .strobe   (strobe),
    .funcRst  (funcRst),
    .rstDone  (rstDone)
  );

  rps_dpath #(
    .NUM_SRC (NUM_SRC),
    .REG_W   (REG_W),
    .P1_CYC  (P1_CYC),
    .P2_CYC  (P2_CYC),
    .P3_CYC  (P3_CYC)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .evtReq     (evtReq),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .privMode   (privMode),
    .strobe     (strobe),
    .regRdData  (regRdData),
    .anyReq     (anyReq),
    .winShort   (winShort),
    .cntZero    (cntZero),
    .srcLatched (srcLatched)
  );

  assign phaseCode = phase;

endmodule

// File: tb/test_reset_phase_sequencer.sv
`timescale 1ns/1ps
module test_reset_phase_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  evtReq = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [1:0]  privMode = 2'b00;
  logic [15:0] regRdData;
  logic [1:0]  phaseCode;
  logic        funcRst;
  logic        rstDone;
  logic [4:0]  srcLatched;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  reset_phase_sequencer i_reset_phase_sequencer (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .regWrEn(regWrEn),
    .regWrData(regWrData), .privMode(privMode), .regRdData(regRdData),
    .phaseCode(phaseCode), .funcRst(funcRst), .rstDone(rstDone),
    .srcLatched(srcLatched)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] mode, input logic [15:0] val);
    @(negedge clk);
    privMode = mode; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; privMode = 2'b00;
  endtask

  task automatic pulse(input logic [4:0] mask);
    @(negedge clk);
    evtReq = mask;
    @(negedge clk);
    evtReq = '0;
  endtask

  // samples from the first cycle of a sequence until idle
  task automatic measure(output int n1, output int n2, output int n3,
                         output int doneAt, input int wrAt, input logic [15:0] wrVal);
    int lastPh = 0;
    int orderBad = 0;
    int rstBad = 0;
    n1 = 0; n2 = 0; n3 = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (phaseCode == 2'd0) break;
      if (int'(phaseCode) < lastPh) orderBad++;
      lastPh = int'(phaseCode);
      if (!funcRst || rstDone) rstBad++;
      if (phaseCode == 2'd1) n1++;
      if (phaseCode == 2'd2) n2++;
      if (phaseCode == 2'd3) n3++;
      if (cyc == wrAt) begin
        privMode = 2'b01; regWrData = wrVal; regWrEn = 1'b1;
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    doneAt = int'(rstDone);
    check("R2 phase order", orderBad, 0);
    check("R9 funcRst/rstDone during phases", rstBad, 0);
    @(negedge clk);
    check("R9 rstDone single cycle", int'(rstDone), 0);
    check("R9 funcRst low when idle", int'(funcRst), 0);
  endtask

  task automatic t_reset();
    check("R1 cfg", int'(regRdData), 0);
    check("R1 phase", int'(phaseCode), 0);
    check("R1 funcRst", int'(funcRst), 0);
    check("R1 rstDone", int'(rstDone), 0);
    check("R1 src", int'(srcLatched), 0);
  endtask

  task automatic t_full();
    int a, b, c, d;
    pulse(5'b00001);
    check("R10 src ext", int'(srcLatched), 1);
    measure(a, b, c, d, -1, 16'h0);
    check("R2 P1 length", a, 8);
    check("R2 P2 length", b, 16);
    check("R2 P3 length", c, 4);
    check("R9 rstDone after P3", d, 1);
    check("R10 src held", int'(srcLatched), 1);
  endtask

  task automatic t_regAccess();
    regWrite(2'b01, 16'hFFFF);
    check("R4 upper bits zero", int'(regRdData), 16'h001F);
    regWrite(2'b00, 16'h0000);
    check("R5 user write ignored", int'(regRdData), 16'h001F);
    regWrite(2'b10, 16'h0000);
    check("R5 test write", int'(regRdData), 0);
    regWrite(2'b11, 16'h001F);
    check("R5 mode 11 ignored", int'(regRdData), 0);
  endtask

  task automatic t_short();
    int a, b, c, d;
    regWrite(2'b01, 16'h0004);
    pulse(5'b00100);
    check("R10 src lvd", int'(srcLatched), 5'b00100);
    measure(a, b, c, d, -1, 16'h0);
    check("R3 no P1", a, 0);
    check("R3 no P2", b, 0);
    check("R3 P3 length", c, 4);
    check("R9 rstDone short", d, 1);
    pulse(5'b00001);
    measure(a, b, c, d, -1, 16'h0);
    check("R4 ext bit0 clear gives full", a + b + c, 28);
  endtask

  task automatic t_priority();
    int a, b, c, d;
    regWrite(2'b01, 16'h0002);
    pulse(5'b10110);
    check("R6 flash wins", int'(srcLatched), 5'b00010);
    measure(a, b, c, d, -1, 16'h0);
    check("R6 flash short", a + b, 0);
    pulse(5'b00011);
    check("R6 ext wins", int'(srcLatched), 5'b00001);
    measure(a, b, c, d, -1, 16'h0);
    check("R6 ext full", a, 8);
  endtask

  task automatic t_sample();
    int a, b, c, d;
    regWrite(2'b01, 16'h0000);
    pulse(5'b01000);
    measure(a, b, c, d, 3, 16'h0008);
    check("R7 mid-sequence write no effect P1", a, 8);
    check("R7 mid-sequence write no effect P3", c, 4);
    check("R7 write landed", int'(regRdData), 16'h0008);
    pulse(5'b01000);
    measure(a, b, c, d, -1, 16'h0);
    check("R7 next sequence short", a + b, 0);
  endtask

  task automatic t_restart();
    int a, b, c, d;
    regWrite(2'b01, 16'h0010);
    pulse(5'b00001);
    repeat (4) @(negedge clk);
    check("R8 in P1 before restart", int'(phaseCode), 1);
    pulse(5'b10000);
    check("R8 src xosc", int'(srcLatched), 5'b10000);
    measure(a, b, c, d, -1, 16'h0);
    check("R8 restart short P1", a, 0);
    check("R8 restart short P3", c, 4);
    pulse(5'b00001);
    repeat (12) @(negedge clk);
    check("R8 in P2 before restart", int'(phaseCode), 2);
    pulse(5'b00010);
    measure(a, b, c, d, -1, 16'h0);
    check("R8 restart full P1", a, 8);
    check("R8 restart full P2", b, 16);
    check("R10 src flash", int'(srcLatched), 5'b00010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_regAccess();
    t_short();
    t_priority();
    t_sample();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule